// File: doc/BRIEF.md
# Video Blanking Signal Generator

This block drives the composite blanking output of a video decoder's pixel stream. A horizontal counter counts pixel clocks from the leading edge of horizontal sync. A line counter counts scan lines within a field and is reloaded at every vertical sync leading edge, with a base line that depends on field parity and video standard. The output blank is high inside a programmable horizontal window on every line. It is also high inside a vertical window in each field. The output is registered.

A small write port holds the horizontal start and end counts and the vertical start value n. Horizontal values take effect from the next line start. Vertical values, parity and standard take effect from the next field start. A window therefore never changes partway through a line or a field. Both horizontal edges land on even pixel counts only.

Top module: `vid_blank_gen`

## Requirements
- R1: While rst_n is low, blank is 0. After reset the horizontal start is 0x34A, the horizontal end is 0x7A, n is 2, the field is odd and the standard is NTSC. Before the first line start the horizontal count rests at 1023 and the line count at 0.
- R2: The horizontal count is 0 in the clock cycle where hs_lead is high and rises by 1 each following clock, saturating at 1023. blank registers the window result of the current cycle's counts, so it changes on the next rising clock edge.
- R3: With horizontal start S and end E: if S <= E, horizontal blanking covers counts S to E-1. If S > E, it covers counts from S upward and counts below E. If S equals E, the window is empty.
- R4: Bit 0 of the horizontal start and end always acts as 0, whatever value is written.
- R5: Write address 0 sets bits 7:0 of the 10-bit horizontal start, address 1 sets bits 9:8 from wr_data[1:0], and address 2 sets the 8-bit horizontal end.
- R6: Address 3 sets bits 7:0 of the 9-bit n, and address 4 sets bit 8 from wr_data[0]. In an odd field (field_even=0) vertical blanking starts on line n+5 and ends before line 22.
- R7: In an even NTSC field vertical blanking starts on line n+268 and ends before line 285. In an even PAL field (pal_mode=1) it starts on line n+318 and ends before line 335. The R3 wrap rule applies to lines.
- R8: On vs_lead the line count loads 1 for an odd field, 264 for an even NTSC field and 314 for an even PAL field. Otherwise it rises by 1 on each hs_lead, saturating at 1023.
- R9: Horizontal register writes apply from the next hs_lead. Writes to n, and the field_even and pal_mode inputs, apply from the next vs_lead. A write in the same cycle as the pulse applies one pulse later.
- R10: Writes to addresses 5, 6 and 7 change nothing.
- R11: blank is the OR of the horizontal and vertical window conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_lead | input | 1 | One-cycle pulse at horizontal sync leading edge |
| vs_lead | input | 1 | One-cycle pulse at vertical sync leading edge |
| field_even | input | 1 | Field parity for the field that starts at vs_lead (1 = even) |
| pal_mode | input | 1 | Standard select sampled at vs_lead (1 = PAL, 0 = NTSC) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| blank | output | 1 | Registered composite blanking output |

## Verification
blank for the counts of a given cycle is due at the next rising edge. The bench therefore updates its own model on that edge and compares blank at the following falling edge, once per clock. A register write is due to show only after the next hs_lead (horizontal) or vs_lead (vertical). The model keeps its own staged and active copies and transfers them on those same pulses, so writes issued mid-line or mid-field are checked in the cycles where they must not yet act. Directed fields cover every parity and standard combination, wrapped windows and a nine-bit n. Random lines, writes and fields cover the rest.

// File: rtl/vid_blank_gen.sv
module vid_blank_gen #(
  parameter int HCW        = 10,
  parameter int LCW        = 10,
  parameter int NTSC_EVEN  = 264,
  parameter int PAL_EVEN   = 314,
  parameter int VSTART_OFS = 4,
  parameter int VEND_OFS   = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_lead,
  input  logic       vs_lead,
  input  logic       field_even,
  input  logic       pal_mode,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       blank
);

  localparam logic [HCW-1:0] HMAX = {HCW{1'b1}};
  localparam logic [LCW-1:0] LMAX = {LCW{1'b1}};

  logic [9:0] sh_hs, act_hs, cur_hs;
  logic [7:0] sh_he, act_he, cur_he;
  logic [8:0] sh_n, act_n, cur_n;
  logic act_even, act_pal, cur_even, cur_pal;
  logic [HCW-1:0] hcnt_q, hpos;
  logic [LCW-1:0] line_q, lpos;
  logic blank_d;
  int vbase, vst, vnd;

  function automatic logic in_win(input int p, input int s, input int e);
    return (s <= e) ? (p >= s && p < e) : (p >= s || p < e);
  endfunction

  function automatic int field_base(input logic even, input logic pal);
    return even ? (pal ? PAL_EVEN : NTSC_EVEN) : 1;
  endfunction

  assign cur_hs   = hs_lead ? sh_hs : act_hs;
  assign cur_he   = hs_lead ? sh_he : act_he;
  assign cur_n    = vs_lead ? sh_n : act_n;
  assign cur_even = vs_lead ? field_even : act_even;
  assign cur_pal  = vs_lead ? pal_mode : act_pal;

  assign hpos = hs_lead ? '0 : ((hcnt_q == HMAX) ? hcnt_q : hcnt_q + HCW'(1));
  assign lpos = vs_lead ? LCW'(field_base(field_even, pal_mode)) :
                hs_lead ? ((line_q == LMAX) ? line_q : line_q + LCW'(1)) : line_q;

  assign vbase = field_base(cur_even, cur_pal);
  assign vst   = vbase + int'(cur_n) + VSTART_OFS;
  assign vnd   = vbase + VEND_OFS;

  assign blank_d = in_win(int'(hpos), int'(cur_hs), int'(cur_he)) |
                   in_win(int'(lpos), vst, vnd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q   <= HMAX;
      line_q   <= '0;
      blank    <= 1'b0;
      sh_hs    <= 10'h34A;
      act_hs   <= 10'h34A;
      sh_he    <= 8'h7A;
      act_he   <= 8'h7A;
      sh_n     <= 9'd2;
      act_n    <= 9'd2;
      act_even <= 1'b0;
      act_pal  <= 1'b0;
    end else begin
      hcnt_q <= hpos;
      line_q <= lpos;
      blank  <= blank_d;
      if (hs_lead) begin
        act_hs <= sh_hs;
        act_he <= sh_he;
      end
      if (vs_lead) begin
        act_n    <= sh_n;
        act_even <= field_even;
        act_pal  <= pal_mode;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: sh_hs[7:0] <= {wr_data[7:1], 1'b0};
          3'd1: sh_hs[9:8] <= wr_data[1:0];
          3'd2: sh_he      <= {wr_data[7:1], 1'b0};
          3'd3: sh_n[7:0]  <= wr_data;
          3'd4: sh_n[8]    <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  // R2
  hcnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_lead |=> hcnt_q == '0);

  // R8
  line_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_lead |=> (line_q == LCW'(1) || line_q == LCW'(NTSC_EVEN) || line_q == LCW'(PAL_EVEN)));

  // R9
  hold_h_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_lead |=> $stable(act_hs) && $stable(act_he));

  // R9
  hold_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_lead |=> $stable(act_n) && $stable(act_even) && $stable(act_pal));

  // R4
  even_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_lead |=> act_hs[0] == 1'b0 && act_he[0] == 1'b0);

endmodule

// File: tb/vid_blank_gen_test.sv
module vid_blank_gen_test;
  logic clk = 0, rst_n = 0;
  logic hs_lead = 0, vs_lead = 0, field_even = 0, pal_mode = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic blank;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit chk_on = 0;
  int wr_mode = 0, wr_pct = 0;

  int m_sh_hs, m_sh_he, m_sh_n, m_a_hs, m_a_he, m_a_n, m_hc, m_ln;
  bit m_a_even, m_a_pal, exp_blank;

  vid_blank_gen uut (.clk(clk), .rst_n(rst_n), .hs_lead(hs_lead), .vs_lead(vs_lead),
    .field_even(field_even), .pal_mode(pal_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .blank(blank));

  always #5 clk = ~clk;

  function automatic bit win(input int p, input int s, input int e);
    if (s <= e) return p >= s && p < e;
    return p >= s || p < e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh_hs = 'h34A; m_a_hs = 'h34A; m_sh_he = 'h7A; m_a_he = 'h7A;
      m_sh_n = 2; m_a_n = 2; m_a_even = 0; m_a_pal = 0;
      m_hc = 1023; m_ln = 0; exp_blank = 0;
    end else begin
      int hp, lp, vs_, ve_;
      hp = hs_lead ? 0 : (m_hc == 1023 ? 1023 : m_hc + 1);
      if (hs_lead) begin m_a_hs = m_sh_hs; m_a_he = m_sh_he; end
      if (vs_lead) begin
        m_a_n = m_sh_n; m_a_even = field_even; m_a_pal = pal_mode;
        lp = field_even ? (pal_mode ? 314 : 264) : 1;
      end else if (hs_lead) lp = (m_ln == 1023) ? 1023 : m_ln + 1;
      else lp = m_ln;
      if (!m_a_even) begin vs_ = m_a_n + 5; ve_ = 22; end
      else if (m_a_pal) begin vs_ = m_a_n + 318; ve_ = 335; end
      else begin vs_ = m_a_n + 268; ve_ = 285; end
      exp_blank = win(hp, m_a_hs, m_a_he) | win(lp, vs_, ve_);
      m_hc = hp; m_ln = lp;
      if (wr_en) begin
        case (wr_addr)
          0: m_sh_hs = (m_sh_hs & 'h300) | (wr_data & 'hFE);
          1: m_sh_hs = (m_sh_hs & 'hFF) | ((wr_data & 3) << 8);
          2: m_sh_he = wr_data & 'hFE;
          3: m_sh_n = (m_sh_n & 'h100) | wr_data;
          4: m_sh_n = (m_sh_n & 'hFF) | ((wr_data & 1) << 8);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      checks++;
      if (blank !== exp_blank) begin
        errors++;
        $display("FAIL %s blank=%0b expected=%0b hc=%0d line=%0d", tag, blank, exp_blank, m_hc, m_ln);
      end
    end
  end

  task automatic drive_wr();
    wr_en = 0;
    if (wr_mode != 0 && ($urandom % 100) < wr_pct) begin
      wr_en = 1;
      wr_data = 8'($urandom);
      case (wr_mode)
        1: wr_addr = 3'($urandom % 3);
        2: wr_addr = 3'(5 + $urandom % 3);
        default: wr_addr = 3'(3 + $urandom % 2);
      endcase
    end
  endtask

  task automatic run_line(input int len, input bit with_vs);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      hs_lead = (i == 0);
      vs_lead = (i == 0) && with_vs;
      drive_wr();
    end
    @(negedge clk);
    hs_lead = 0; vs_lead = 0; wr_en = 0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    hs_lead = 0; vs_lead = 0;
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run_field(input bit ev, input bit pal, input int nlines);
    field_even = ev; pal_mode = pal;
    for (int l = 0; l < nlines; l++) run_line(16, l == 0);
  endtask

  task automatic set_n(input int n);
    wr(3, n & 'hFF);
    wr(4, n >> 8);
  endtask

  initial begin
    #19_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    checks++;
    if (blank !== 1'b0) begin errors++; $display("FAIL R1 reset blank=%0b expected=0", blank); end
    @(negedge clk); rst_n = 1;
    chk_on = 1;
    tag = "R1";
    repeat (5) @(negedge clk);
    tag = "R2 R3 R5";
    repeat (3) run_line(1000, 0);
    tag = "R4 R5";
    wr(0, 'h21); wr(1, 0); wr(2, 'h41);
    repeat (2) run_line(100, 0);
    tag = "R3 wrap";
    wr(0, 'h51); wr(2, 'h11);
    repeat (2) run_line(120, 0);
    tag = "R9 R4 random";
    wr_mode = 1; wr_pct = 2;
    repeat (20) run_line(200 + $urandom % 900, 0);
    tag = "R10";
    wr_mode = 2; wr_pct = 20;
    repeat (4) run_line(300, 0);
    wr_mode = 0;
    tag = "R7 R8 setup";
    wr(0, 'h10); wr(1, 0); wr(2, 'h10);
    set_n(2);
    tag = "R6 odd NTSC";   run_field(0, 0, 30);
    tag = "R7 even NTSC";  run_field(1, 0, 30);
    tag = "R7 even PAL";   run_field(1, 1, 30);
    set_n(40);
    tag = "R6 odd PAL wrap"; run_field(0, 1, 50);
    set_n(300);
    tag = "R7 even n high"; run_field(1, 0, 310);
    set_n(511);
    tag = "R6 odd n max";  run_field(0, 0, 30);
    set_n(10);
    tag = "R11";
    wr(0, 'h04); wr(2, 'h08);
    run_field(1, 1, 30);
    run_field(0, 0, 20);
    tag = "R9 R8 random fields";
    for (int f = 0; f < 8; f++) begin
      wr_mode = 3; wr_pct = 1;
      run_field(1'($urandom), 1'($urandom), 30 + $urandom % 90);
    end
    wr_mode = 0;
    tag = "R8 R9 final";
    run_field(0, 0, 25);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule